// File: doc/BRIEF.md
# Command-Port Buffer Access Sequencer

This block sits on a processor's host bus as a slave. It gives the processor access to a small internal buffer RAM of 16-bit words and to a few control registers. There are only two ports. The processor first writes a command word to the command port. It then moves data through the data port. A register command is followed by exactly one data access. A buffer command opens an access cycle that lasts for half of the programmed byte count in words. During that cycle the block steps the buffer address by one word per data access.

Each access cycle is locked to the direction given by its command. A data access in the wrong direction, one made after the cycle has closed, or one that lowers both strobes together is dropped. Any of these raises a sticky error flag, which software reads and clears through its own register code.

The bus is synchronous. Every rising clock edge with chip select low and one strobe low counts as one access.

Top module: `cmdport_buf_seq`

## Requirements
- R1: After reset the block is idle. The byte-count, configuration and error registers all read 0, and `dout` is 0 while no read-type command is pending.
- R2: Command 0xA2 followed by one data write loads the byte-count register. Command 0xA1 followed by one data write loads the configuration register. Commands 0x22 and 0x21 followed by one data read return those registers. A write code is always the read code with bit 7 set.
- R3: Command 0xC0 opens a buffer write cycle that accepts exactly floor(byte count / 2) data writes. These are stored at word addresses 0, 1, 2 and upward.
- R4: Command 0x40 opens a buffer read cycle. Its data reads return the stored words starting at word address 0 and moving up by one per read.
- R5: After the last word of a cycle the block is idle. A further data access is ignored, `dout` reads 0, and the error flag is set.
- R6: During a buffer cycle, a data access of the opposite direction is ignored. It sets the error flag and does not advance the cycle's position.
- R7: The error flag is bit 0 of the word returned by command 0x24 followed by a data read. All other bits of that word are 0. The flag stays set until that read, which clears it.
- R8: An access with both strobes low is ignored. It sets the error flag and does not advance the buffer position.
- R9: A command write in the middle of a buffer cycle abandons that cycle without error. A new buffer cycle restarts at word address 0.
- R10: With a byte count below 2, a buffer command opens no cycle, and the next data access sets the error flag.
- R11: Only bits 7:0 of a command word are decoded. An unknown code leaves the block idle and does not set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| port_sel | input | 1 | 1 selects the command port, 0 selects the data port |
| din | input | DW | Write data or command word |
| dout | output | DW | Read data, valid while a read-type command is pending |

## Verification
Two of the block's functions can fall on the same cycle: the error flag and the buffer address step. Both react to a data-port access. The bench provokes this by lowering both strobes in the middle of a buffer write cycle. It then reads the cycle back to confirm that exactly the words written with a single strobe landed at consecutive addresses. Finally it reads the error register and expects the flag to be set.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REG_WR, ST_REG_RD, ST_BUF_WR, ST_BUF_RD
  } seq_state_t;

  typedef enum logic [1:0] {
    TG_NONE, TG_COUNT, TG_CONFIG, TG_ERROR
  } reg_tgt_t;

  // read codes; the write code of each sets bit 7
  localparam logic [6:0] CODE_CONFIG = 7'h21;
  localparam logic [6:0] CODE_COUNT  = 7'h22;
  localparam logic [6:0] CODE_ERROR  = 7'h24;
  localparam logic [6:0] CODE_BUF    = 7'h40;

  // words moved by one buffer cycle for a given byte count
  function automatic int unsigned words_of(input int unsigned bytes);
    return bytes >> 1;
  endfunction

endpackage

// File: rtl/cmdport_decode.sv
module cmdport_decode
  import cmdport_pkg::*;
(
  input  logic [7:0] code,
  output seq_state_t nxt,
  output reg_tgt_t   tgt
);
  logic       is_wr;
  logic [6:0] base;

  assign is_wr = code[7];
  assign base  = code[6:0];

  always_comb begin
    nxt = ST_IDLE;
    tgt = TG_NONE;
    case (base)
      CODE_COUNT: begin
        nxt = is_wr ? ST_REG_WR : ST_REG_RD;
        tgt = TG_COUNT;
      end
      CODE_CONFIG: begin
        nxt = is_wr ? ST_REG_WR : ST_REG_RD;
        tgt = TG_CONFIG;
      end
      CODE_ERROR: begin
        if (!is_wr) begin
          nxt = ST_REG_RD;
          tgt = TG_ERROR;
        end
      end
      CODE_BUF: nxt = is_wr ? ST_BUF_WR : ST_BUF_RD;
      default: ;
    endcase
  end
endmodule

// File: rtl/cmdport_addr.sv
module cmdport_addr #(
  parameter int AW = 6,
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_words,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] left,
  output logic          last
);
  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      left <= '0;
    end else if (load) begin
      addr <= '0;
      left <= load_words;
    end else if (adv) begin
      addr <= step(addr);
      left <= left - CW'(1);
    end
  end

  assign last = (left == CW'(1));
endmodule

// File: rtl/cmdport_ram.sv
module cmdport_ram #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cmdport_buf_seq.sv
module cmdport_buf_seq
  import cmdport_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          port_sel,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int CW = DW - 1;

  // bus events
  logic wr_act, rd_act, conflict, cmd_wr, dat_wr, dat_rd;
  assign wr_act   = !cs_n && !wr_n;
  assign rd_act   = !cs_n && !rd_n;
  assign conflict = wr_act && rd_act;
  assign cmd_wr   = wr_act && !rd_act && port_sel;
  assign dat_wr   = wr_act && !rd_act && !port_sel;
  assign dat_rd   = rd_act && !wr_act && !port_sel;

  seq_state_t    state_q;
  reg_tgt_t      tgt_q;
  logic [DW-1:0] count_q, cfg_q;
  logic          err_q;

  seq_state_t dec_nxt;
  reg_tgt_t   dec_tgt;

  cmdport_decode u_dec (
    .code (din[7:0]),
    .nxt  (dec_nxt),
    .tgt  (dec_tgt)
  );

  // named internal events
  logic          buf_cmd, open_ok, buf_adv, reg_done, err_evt, err_clr, last;
  logic [CW-1:0] words, left;
  logic [AW-1:0] addr;
  logic [DW-1:0] ram_q;

  assign words    = CW'(words_of(32'(count_q)));
  assign open_ok  = (words != '0);
  assign buf_cmd  = cmd_wr && (dec_nxt == ST_BUF_WR || dec_nxt == ST_BUF_RD);
  assign buf_adv  = (state_q == ST_BUF_WR && dat_wr) ||
                    (state_q == ST_BUF_RD && dat_rd);
  assign reg_done = (state_q == ST_REG_WR && dat_wr) ||
                    (state_q == ST_REG_RD && dat_rd);
  assign err_evt  = conflict ||
                    (dat_wr && state_q != ST_REG_WR && state_q != ST_BUF_WR) ||
                    (dat_rd && state_q != ST_REG_RD && state_q != ST_BUF_RD);
  assign err_clr  = state_q == ST_REG_RD && dat_rd && tgt_q == TG_ERROR;

  cmdport_addr #(.AW(AW), .CW(CW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (buf_cmd),
    .load_words (words),
    .adv        (buf_adv),
    .addr       (addr),
    .left       (left),
    .last       (last)
  );

  cmdport_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (state_q == ST_BUF_WR && dat_wr),
    .waddr (addr),
    .wdata (din),
    .raddr (addr),
    .rdata (ram_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= TG_NONE;
    end else if (cmd_wr) begin
      state_q <= (buf_cmd && !open_ok) ? ST_IDLE : dec_nxt;
      tgt_q   <= dec_tgt;
    end else if (reg_done || (buf_adv && last)) begin
      state_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      cfg_q   <= '0;
    end else if (state_q == ST_REG_WR && dat_wr) begin
      if (tgt_q == TG_COUNT)  count_q <= din;
      if (tgt_q == TG_CONFIG) cfg_q   <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (err_evt) err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  always_comb begin
    dout = '0;
    case (state_q)
      ST_REG_RD: begin
        case (tgt_q)
          TG_COUNT:  dout = count_q;
          TG_CONFIG: dout = cfg_q;
          TG_ERROR:  dout = {{(DW-1){1'b0}}, err_q};
          default:   dout = '0;
        endcase
      end
      ST_BUF_RD: dout = ram_q;
      default:   dout = '0;
    endcase
  end
endmodule

// File: rtl/cmdport_buf_seq_chk.sv
module cmdport_buf_seq_chk
  import cmdport_pkg::*;
#(
  parameter int AW = 6,
  parameter int CW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input seq_state_t    state_q,
  input logic          err_q,
  input logic          err_evt,
  input logic          err_clr,
  input logic          conflict,
  input logic          buf_cmd,
  input logic          open_ok,
  input logic          buf_adv,
  input logic          last,
  input logic [AW-1:0] addr,
  input logic [CW-1:0] left
);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> err_q);

  // R7
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(err_evt));

  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !err_evt) |=> !err_q);

  // R8
  conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> $stable(addr));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_adv && !last) |=> (addr - $past(addr)) == AW'(1));

  // R5
  cycle_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_adv && last) |=> state_q == ST_IDLE);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_cmd && open_ok) |=> (addr == '0 && left != '0));

  // R10
  empty_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_cmd && !open_ok) |=> state_q == ST_IDLE);
endmodule

bind cmdport_buf_seq cmdport_buf_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .state_q  (state_q),
  .err_q    (err_q),
  .err_evt  (err_evt),
  .err_clr  (err_clr),
  .conflict (conflict),
  .buf_cmd  (buf_cmd),
  .open_ok  (open_ok),
  .buf_adv  (buf_adv),
  .last     (last),
  .addr     (addr),
  .left     (left)
);

// File: tb/cmdport_buf_seq_tb.sv
`timescale 1ns/1ps
module cmdport_buf_seq_tb;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_BOTH = 2'd2, OP_NONE = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, port_sel = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  int          nvec = 0;
  int          nfail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cmdport_buf_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .port_sel(port_sel), .din(din), .dout(dout)
  );

  // vector: {op[22:21], cmd[20], data[19:4], req[3:0]}; req 0 = no check,
  // for reads the data field is the expected value
  localparam logic [22:0] VEC [0:24] = '{
    {OP_WR, 1'b1, 16'h00A2, 4'd0},
    {OP_WR, 1'b0, 16'h0008, 4'd0},
    {OP_WR, 1'b1, 16'h0022, 4'd0},
    {OP_RD, 1'b0, 16'h0008, 4'd2},   // R2
    {OP_WR, 1'b1, 16'h00A1, 4'd0},
    {OP_WR, 1'b0, 16'h5A5A, 4'd0},
    {OP_WR, 1'b1, 16'h0021, 4'd0},
    {OP_RD, 1'b0, 16'h5A5A, 4'd2},   // R2
    {OP_WR, 1'b1, 16'h00C0, 4'd0},
    {OP_WR, 1'b0, 16'h1111, 4'd0},
    {OP_WR, 1'b0, 16'h2222, 4'd0},
    {OP_WR, 1'b0, 16'h3333, 4'd0},
    {OP_WR, 1'b0, 16'h4444, 4'd0},
    {OP_WR, 1'b1, 16'h0024, 4'd0},
    {OP_RD, 1'b0, 16'h0000, 4'd7},   // R7 no error yet
    {OP_WR, 1'b1, 16'h0040, 4'd0},
    {OP_RD, 1'b0, 16'h1111, 4'd4},   // R4
    {OP_RD, 1'b0, 16'h2222, 4'd3},   // R3
    {OP_RD, 1'b0, 16'h3333, 4'd4},
    {OP_RD, 1'b0, 16'h4444, 4'd3},
    {OP_RD, 1'b0, 16'h0000, 4'd5},   // R5 excess read
    {OP_WR, 1'b1, 16'h0024, 4'd0},
    {OP_RD, 1'b0, 16'h0001, 4'd5},   // R5 error set
    {OP_WR, 1'b1, 16'h0024, 4'd0},
    {OP_RD, 1'b0, 16'h0000, 4'd7}    // R7 cleared by read
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] op, input logic cmd, input logic [15:0] d,
                     output logic [15:0] q);
    @(negedge clk);
    cs_n     = (op == OP_NONE);
    wr_n     = !(op == OP_WR || op == OP_BOTH);
    rd_n     = !(op == OP_RD || op == OP_BOTH);
    port_sel = cmd;
    din      = d;
    #1 q = dout;
    @(posedge clk);
  endtask

  task automatic wcmd(input logic [15:0] c);
    logic [15:0] q;
    acc(OP_WR, 1'b1, c, q);
  endtask

  task automatic wdat(input logic [15:0] d);
    logic [15:0] q;
    acc(OP_WR, 1'b0, d, q);
  endtask

  task automatic rchk(input string req, input logic [15:0] exp);
    logic [15:0] q;
    acc(OP_RD, 1'b0, 16'h0, q);
    check(req, q, exp);
  endtask

  task automatic rreg(input logic [15:0] code, input string req, input logic [15:0] exp);
    wcmd(code);
    rchk(req, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] q;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    acc(OP_NONE, 1'b0, 16'h0, q);
    check("R1", q, 16'h0000);
    rreg(16'h0022, "R1", 16'h0000);
    rreg(16'h0021, "R1", 16'h0000);
    rreg(16'h0024, "R1", 16'h0000);

    for (int i = 0; i < 25; i++) begin
      acc(VEC[i][22:21], VEC[i][20], VEC[i][19:4], q);
      if (VEC[i][3:0] != 4'd0)
        check($sformatf("R%0d", VEC[i][3:0]), q, VEC[i][19:4]);
    end

    // R6 wrong direction inside a write cycle
    wcmd(16'h00A2); wdat(16'h0006);
    wcmd(16'h00C0); wdat(16'hAAAA);
    acc(OP_RD, 1'b0, 16'h0, q);
    wdat(16'hBBBB); wdat(16'hCCCC);
    wcmd(16'h0040);
    rchk("R6", 16'hAAAA); rchk("R6", 16'hBBBB); rchk("R6", 16'hCCCC);
    rreg(16'h0024, "R6", 16'h0001);

    // R8 both strobes low in mid cycle
    wcmd(16'h00C0); wdat(16'h0101);
    acc(OP_BOTH, 1'b0, 16'h0202, q);
    wdat(16'h0303); wdat(16'h0404);
    wcmd(16'h0040);
    rchk("R8", 16'h0101); rchk("R8", 16'h0303); rchk("R8", 16'h0404);
    rreg(16'h0024, "R8", 16'h0001);

    // R9 restart in mid cycle
    wcmd(16'h00C0); wdat(16'h7777);
    wcmd(16'h00C0); wdat(16'h8888); wdat(16'h9999); wdat(16'hAAAA);
    wcmd(16'h0040);
    rchk("R9", 16'h8888);
    rreg(16'h0024, "R9", 16'h0000);

    // R10 byte count below two
    wcmd(16'h00A2); wdat(16'h0001);
    wcmd(16'h00C0); wdat(16'hDEAD);
    rreg(16'h0024, "R10", 16'h0001);
    rreg(16'h0022, "R10", 16'h0001);

    // R11 only the low byte is decoded
    wcmd(16'h1234);
    rreg(16'h0024, "R11", 16'h0000);
    wcmd(16'h00A2); wdat(16'h0004);
    wcmd(16'hFFC0); wdat(16'h1357); wdat(16'h2468);
    wcmd(16'hFF40);
    rchk("R11", 16'h1357); rchk("R11", 16'h2468);

    acc(OP_NONE, 1'b0, 16'h0, q);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule